// File: doc/BRIEF.md
# Incremental Converter Decimator with Adaptive Bias Control

This block is the digital back end of a second-order incremental delta-sigma converter used in a column readout. A start pulse opens a conversion window of a fixed number of modulator cycles. In each cycle of that window the block takes one 1-bit modulator decision, feeds it into a two-stage integrator cascade, and at the end of the window turns the cascade's final value into a 12-bit code. It presents that code with a one-cycle valid strobe.

Alongside the decimation, the block drives a 4-bit word that switches four unit current sources in the first integrator's amplifier. An always-on source supplies the minimum current, and the four switched units add to it. The word comes from a coarse 4-bit input estimate and from the modulator decision of the current cycle. It is combinational from that decision, so it is settled before the integration phase that uses it. A bypass input forces every unit source on. Between conversions, every unit source is also on.

Top module: `iadc_bias_ctrl`

## Requirements
- R1: After reset, `bias_word_o` is 4'b1111, `code_vld_o` is 0 and `code_o` is 0.
- R2: A high `start_i` sampled at a clock edge while no conversion runs clears both integrators and opens a conversion. The next N = 100 clock edges each consume one `bit_i`, and `code_vld_o` is high during the cycle that follows the edge consuming the 100th bit.
- R3: A high `start_i` while a conversion runs is ignored. Neither the code nor the strobe timing changes.
- R4: `bit_i` = 1 stands for +1 and `bit_i` = 0 stands for -1. For each consumed value x: s1 <= s1 + x, then s2 <= s2 + s1(new).
- R5: The final code is round((s2 + M) * 4095 / (2M)), computed as (off*4095 + M) / (2M) with integer division, where M = N(N+1)/2 = 5050.
- R6: While a conversion runs and `bias_en_i` = 1, `bias_word_o` is the bitwise inverse of the coarse estimate E when `bit_i` = 1, and is E itself when `bit_i` = 0.
- R7: While `bias_en_i` = 0, `bias_word_o` is 4'b1111.
- R8: While no conversion runs, `bias_word_o` is 4'b1111.
- R9: E is bits [11:8] of the most recent final code, in offset binary (0000 most negative, 1000 zero, 1111 most positive). After reset, E is 4'b1000.
- R10: `code_vld_o` lasts exactly one cycle. `code_o` holds its value until the next strobe.
- R11: The corner mappings hold. With E = 1111, the word is 1111 for bit 0 and 0000 for bit 1. With E = 0000, the word is 0000 for bit 0 and 1111 for bit 1. With E = 1000, the word is 1000 for bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one modulator cycle per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a conversion when the block is idle |
| bit_i | input | 1 | Modulator decision, 1 = +1, 0 = -1 |
| bias_en_i | input | 1 | 1 = adaptive bias, 0 = all unit sources on |
| code_o | output | 12 | Final conversion code |
| code_vld_o | output | 1 | One-cycle strobe marking a new code |
| bias_word_o | output | 4 | Unit current source enables |

## Verification
The bias word depends combinationally on `bit_i`, so the bench checks it in the same cycle the bit is driven, shortly after the falling edge. The final code is due one cycle after the edge that consumes the 100th bit. The driver therefore checks the strobe at the falling edge 101 cycles after the start edge, and checks that it has dropped one cycle later. A monitor pops each expected code, which the driver computes from R4 and R5, on every strobe. The driver's estimate model follows R9, so the bias expectations carry over from one conversion to the next.

// File: rtl/iadc_pkg.sv
package iadc_pkg;
    typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/iadc_cic2.sv
module iadc_cic2 #(
    parameter int N = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic bit_i,
    output logic signed [$clog2(N*(N+1)/2+1):0] sum_nxt_o
);
    localparam int W1 = $clog2(N + 1) + 1;
    localparam int W2 = $clog2(N * (N + 1) / 2 + 1) + 1;

    typedef struct packed {
        logic signed [W1-1:0] s1;
        logic signed [W2-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.s1 = '0;
            st_d.s2 = '0;
        end else if (step_i) begin
            st_d.s1 = st_q.s1 + (bit_i ? W1'(1) : -W1'(1));
            st_d.s2 = st_q.s2 + {{(W2-W1){st_d.s1[W1-1]}}, st_d.s1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_nxt_o = st_d.s2;

    // R2: a clear leaves both stages at zero
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.s1 == '0 && st_q.s2 == '0));
    // R4: first stage moves by exactly one per consumed bit
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> (st_q.s1 - $past(st_q.s1) == W1'(1) ||
                               $past(st_q.s1) - st_q.s1 == W1'(1)));
endmodule

// File: rtl/iadc_bias_map.sv
module iadc_bias_map #(
    parameter int BW = 4
) (
    input  logic          run_i,
    input  logic          en_i,
    input  logic          bit_i,
    input  logic [BW-1:0] est_i,
    output logic [BW-1:0] word_o
);
    always_comb begin
        if (!run_i || !en_i) word_o = '1;
        else if (bit_i)      word_o = ~est_i;
        else                 word_o = est_i;
    end
endmodule

// File: rtl/iadc_bias_ctrl.sv
module iadc_bias_ctrl #(
    parameter int N      = 100,
    parameter int CODE_W = 12,
    parameter int BW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bit_i,
    input  logic              bias_en_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o,
    output logic [BW-1:0]     bias_word_o
);
    import iadc_pkg::*;

    localparam int    CNT_W    = $clog2(N);
    localparam int    SW       = $clog2(N * (N + 1) / 2 + 1) + 1;
    localparam longint MAXSUM  = longint'(N) * longint'(N + 1) / 2;
    localparam longint SPAN    = 2 * MAXSUM;
    localparam longint CODE_MX = (longint'(1) << CODE_W) - 1;

    typedef struct packed {
        phase_t             ph;
        logic [CNT_W-1:0]   cnt;
        logic [CODE_W-1:0]  code;
        logic               vld;
        logic [BW-1:0]      est;
    } st_t;

    st_t st_d, st_q;
    logic              go, step;
    logic signed [SW-1:0] sum_nxt;
    logic signed [63:0] off_w;
    logic signed [63:0] quot_w;

    assign go   = (st_q.ph == PH_IDLE) && start_i;
    assign step = (st_q.ph == PH_RUN);

    iadc_cic2 #(.N(N)) u_cic (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (go),
        .step_i   (step),
        .bit_i    (bit_i),
        .sum_nxt_o(sum_nxt)
    );

    iadc_bias_map #(.BW(BW)) u_map (
        .run_i (step),
        .en_i  (bias_en_i),
        .bit_i (bit_i),
        .est_i (st_q.est),
        .word_o(bias_word_o)
    );

    always_comb begin
        off_w  = 64'(sum_nxt) + 64'(MAXSUM);
        quot_w = (off_w * CODE_MX + MAXSUM) / SPAN;
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (go) begin
            st_d.ph  = PH_RUN;
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == CNT_W'(N - 1)) begin
                st_d.ph   = PH_IDLE;
                st_d.cnt  = '0;
                st_d.code = quot_w[CODE_W-1:0];
                st_d.est  = quot_w[CODE_W-1:CODE_W-BW];
                st_d.vld  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.est  <= {1'b1, {(BW-1){1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o     = st_q.code;
    assign code_vld_o = st_q.vld;

    // R8: idle means every unit source on
    a_r8_idle_max: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE) |-> (bias_word_o == '1));
    // R7: bypass forces every unit source on
    a_r7_bypass_max: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_en_i |-> (bias_word_o == '1));
    // R10: the strobe is one cycle wide
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld_o |=> !code_vld_o);
    // R10: the code only moves together with the strobe
    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> code_vld_o);
    // R2: the cycle counter stays inside the window
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(N));
    // R3: a start during a conversion does not restart the count
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start_i && st_q.cnt != CNT_W'(N - 1)) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: tb/sim_iadc_bias_ctrl.sv
module sim_iadc_bias_ctrl;
    localparam int N = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       bias_en_i = 1'b1;
    logic [11:0] code_o;
    logic       code_vld_o;
    logic [3:0] bias_word_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    logic [3:0] est_m = 4'b1000;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iadc_bias_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_i(bit_i),
        .bias_en_i(bias_en_i), .code_o(code_o), .code_vld_o(code_vld_o),
        .bias_word_o(bias_word_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pbit(input int kind, input int i);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (i % 2) == 0;
            default: return (i % 4) != 0;
        endcase
    endfunction

    // drives one conversion, checks bias per cycle and strobe timing
    task automatic run_conv(input int kind, input logic en, input bit mid_start);
        longint s1 = 0, s2 = 0, code;
        logic [3:0] bw;
        @(negedge clk);
        bias_en_i = en;
        start_i = 1'b1;
        #1 chk("R8 idle bias", bias_word_o, 15);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            start_i = (mid_start && i == 40);
            bit_i = pbit(kind, i);
            s1 += bit_i ? 1 : -1;
            s2 += s1;
            bw = !en ? 4'hF : (bit_i ? ~est_m : est_m);
            #1;
            if (i == 0 || i == 1 || i == N - 1)
                chk(en ? "R6/R11 bias word" : "R7 bypass bias", bias_word_o, int'(bw));
            else if (bias_word_o != bw)
                chk("R6 bias word", bias_word_o, int'(bw));
        end
        code = ((s2 + 5050) * 4095 + 5050) / 10100;
        exp_q.push_back(int'(code));
        est_m = code[11:8];
        start_i = 1'b0;
        @(negedge clk);
        chk("R2 strobe timing", code_vld_o, 1);
        chk("R8 bias after end", bias_word_o, 15);
        @(negedge clk);
        chk("R10 strobe width", code_vld_o, 0);
        chk("R10 code hold", code_o, int'(code));
    endtask

    always @(negedge clk) begin
        if (rst_n && code_vld_o) begin
            if (exp_q.size() == 0) chk("R2 unexpected strobe", 1, 0);
            else chk("R5 code value", code_o, exp_q.pop_front());
        end
    end

    initial begin
        #25000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #5;
        chk("R1 bias at reset", bias_word_o, 15);
        chk("R1 strobe at reset", code_vld_o, 0);
        chk("R1 code at reset", code_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_conv(0, 1'b1, 1'b0);  // R9 start estimate 1000
        run_conv(1, 1'b1, 1'b0);  // R11 estimate 1111
        run_conv(0, 1'b1, 1'b0);  // R11 estimate 0000
        run_conv(2, 1'b1, 1'b1);  // R3 start mid conversion, R4
        run_conv(3, 1'b0, 1'b0);  // R7 bypass
        run_conv(3, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 all codes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule